// File: doc/BRIEF.md
# Vector Catch Detector

This block watches the instruction prefetch stream of a processor core. It raises a debug event when an instruction fetched from one of the eight exception vector locations later commits, provided that software enabled catching for that vector. Any prefetch from a vector address counts. It does not have to come from a real exception entry: a branch that lands on a vector slot qualifies just as well.

Each fetch carries a tag. The match is decided when the fetch is seen, using the enable register and the halting-mode input as they stand in that cycle, and it is held against the tag. When the core later commits that tag, the block emits a one-cycle event pulse. The commit interface carries no condition-code outcome, so an instruction that fails its condition still reports. A cancel from the pipeline discards every match not yet committed.

The prefetch-abort and data-abort slots are special. A match on either one is dropped unless halting debug mode is active at fetch time.

Top module: `vcatch_detect`

## Requirements
- R1: The vector table holds eight word-aligned slots at offsets 0x00, 0x04, …, 0x1C from a base. The base is 0x00000000 when `hivec_sel` is 0 and 0xFFFF0000 when it is 1. The slot index is offset/4. Any other address, including a misaligned one inside the table, never matches.
- R2: Every `pf_valid` cycle whose address falls on an enabled slot records a match for `pf_tag`. No exception-entry qualifier is involved.
- R3: The match uses enable bit `idx` of the enable register as it stands in the fetch cycle. Writes made after the fetch do not change the outcome.
- R4: Slot 3 (prefetch abort, offset 0x0C) and slot 4 (data abort, offset 0x10) match only if `halt_mode` is 1 in the fetch cycle.
- R5: Writing `cfg_wdata` with `cfg_we`=1 loads the enable register, with bit `i` enabling slot `i`. Bit 5 (reserved slot 0x14) is forced to 0, so `cfg_rdata[5]` always reads 0 and slot 5 never matches.
- R6: `catch_evt` is high for exactly the cycle after a `commit_valid` cycle whose `commit_tag` holds a recorded match.
- R7: `cancel` discards all recorded matches. A commit in the same cycle as the cancel is still reported. A prefetch in the same cycle as the cancel is still recorded.
- R8: After reset the enable register reads 0, no match is recorded and `catch_evt` is 0.
- R9: Committing a tag with no recorded match gives no event. A commit clears its tag, so a second commit of that tag gives no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pf_valid | input | 1 | Prefetch address is valid this cycle |
| pf_addr | input | ADDR_W | Prefetch virtual address |
| pf_tag | input | TAG_W | Tag of the fetched instruction |
| hivec_sel | input | 1 | Selects the high vector base |
| halt_mode | input | 1 | Halting debug mode enabled |
| commit_valid | input | 1 | An instruction commits this cycle |
| commit_tag | input | TAG_W | Tag of the committing instruction |
| cancel | input | 1 | Discard all uncommitted matches |
| cfg_we | input | 1 | Enable register write strobe |
| cfg_wdata | input | 8 | Enable register write data |
| cfg_rdata | output | 8 | Enable register contents |
| catch_evt | output | 1 | Vector catch event pulse |

## Verification
A cancel and a commit can arrive in the same cycle, and a prefetch can coincide with both. The bench records matches on two tags and then raises cancel together with the commit of one of them. It expects an event for the committing tag. It then commits the other tag and expects silence. It also fetches a vector address in a cancel cycle and expects the commit of that tag to report.

// File: rtl/vcatch_detect.sv
module vcatch_detect #(
  parameter int TAG_W = 3,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] HI_BASE = 'hFFFF0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  input  logic [TAG_W-1:0]  pf_tag,
  input  logic              hivec_sel,
  input  logic              halt_mode,
  input  logic              commit_valid,
  input  logic [TAG_W-1:0]  commit_tag,
  input  logic              cancel,
  input  logic              cfg_we,
  input  logic [7:0]        cfg_wdata,
  output logic [7:0]        cfg_rdata,
  output logic              catch_evt
);

  localparam int NVEC  = 8;
  localparam int OFS_W = 5;
  localparam int DEPTH = 1 << TAG_W;
  localparam logic [NVEC-1:0] RSV_MASK = 8'h20;

  logic [NVEC-1:0]  en_q;
  logic [DEPTH-1:0] pend_q, pend_n;
  logic             evt_q;

  wire [ADDR_W-1:0] base     = hivec_sel ? HI_BASE : '0;
  wire              in_table = (pf_addr[ADDR_W-1:OFS_W] == base[ADDR_W-1:OFS_W]) && (pf_addr[1:0] == 2'b00);
  wire [2:0]        vidx     = pf_addr[4:2];
  wire              is_abort = (vidx == 3'd3) || (vidx == 3'd4);
  wire              hit      = pf_valid && in_table && en_q[vidx] && (!is_abort || halt_mode);

  assign cfg_rdata = en_q;
  assign catch_evt = evt_q;

  always_comb begin
    pend_n = pend_q;
    if (commit_valid) pend_n[commit_tag] = 1'b0;
    if (cancel)       pend_n = '0;
    if (pf_valid)     pend_n[pf_tag] = hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
      evt_q  <= 1'b0;
    end else begin
      if (cfg_we) en_q <= cfg_wdata & ~RSV_MASK;
      pend_q <= pend_n;
      evt_q  <= commit_valid && pend_q[commit_tag];
    end
  end

  a_r6_evt_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    catch_evt |-> $past(commit_valid));

  a_r5_rsv_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[5] == 1'b0);

  a_r4_abort_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !halt_mode && in_table && is_abort) |=> !pend_q[$past(pf_tag)]);

  a_r1_misaligned_no_match: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && pf_addr[1:0] != 2'b00) |=> !pend_q[$past(pf_tag)]);

  a_r7_cancel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cancel && !pf_valid) |=> (pend_q == '0));

  a_r9_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_valid && !(pf_valid && pf_tag == commit_tag)) |=> !pend_q[$past(commit_tag)]);

endmodule

// File: tb/vcatch_detect_tb.sv
module vcatch_detect_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        pf_valid = 0;
  logic [31:0] pf_addr = '0;
  logic [2:0]  pf_tag = '0;
  logic        hivec_sel = 0;
  logic        halt_mode = 0;
  logic        commit_valid = 0;
  logic [2:0]  commit_tag = '0;
  logic        cancel = 0;
  logic        cfg_we = 0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  cfg_rdata;
  logic        catch_evt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  vcatch_detect u_dut (
    .clk(clk), .rst_n(rst_n), .pf_valid(pf_valid), .pf_addr(pf_addr), .pf_tag(pf_tag),
    .hivec_sel(hivec_sel), .halt_mode(halt_mode), .commit_valid(commit_valid),
    .commit_tag(commit_tag), .cancel(cancel), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .catch_evt(catch_evt)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [31:0] a, input bit hv, input bit hm, input logic [7:0] m);
    logic [31:0] b;
    logic [7:0]  em;
    int i;
    b  = hv ? 32'hFFFF0000 : 32'h0;
    em = m & 8'hDF;
    if (a[31:5] != b[31:5] || a[1:0] != 2'b00) return 0;
    i = int'(a[4:2]);
    if ((i == 3 || i == 4) && !hm) return 0;
    return em[i];
  endfunction

  task automatic wr_en(input logic [7:0] v);
    @(negedge clk); cfg_we = 1; cfg_wdata = v;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic fetch(input logic [31:0] a, input logic [2:0] t);
    @(negedge clk); pf_valid = 1; pf_addr = a; pf_tag = t;
    @(negedge clk); pf_valid = 0;
  endtask

  task automatic commit_chk(input logic [2:0] t, input int exp, input string req);
    @(negedge clk); commit_valid = 1; commit_tag = t;
    @(negedge clk); commit_valid = 0;
    check(req, int'(catch_evt), exp);
  endtask

  logic [31:0] addrs [12];

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R8 enable reset", int'(cfg_rdata), 0);
    check("R8 evt reset", int'(catch_evt), 0);
    commit_chk(3'd0, 0, "R8 no pending after reset");

    wr_en(8'hFF);
    check("R5 bit5 masked", int'(cfg_rdata), 8'hDF);
    wr_en(8'h20);
    check("R5 only bit5 written", int'(cfg_rdata), 0);

    for (int hv = 0; hv < 2; hv++) begin
      for (int hm = 0; hm < 2; hm++) begin
        for (int m = 0; m < 256; m++) begin
          logic [31:0] b;
          b = hv ? 32'hFFFF0000 : 32'h0;
          hivec_sel = hv[0]; halt_mode = hm[0];
          wr_en(m[7:0]);
          for (int k = 0; k < 8; k++) addrs[k] = b + 32'(k * 4);
          addrs[8]  = b + 32'h20;
          addrs[9]  = b + 32'h02;
          addrs[10] = hv ? 32'h0 : 32'hFFFF0000;
          addrs[11] = 32'h1000_0004;
          for (int k = 0; k < 12; k++) begin
            fetch(addrs[k], 3'(k));
            commit_chk(3'(k), int'(exp_hit(addrs[k], hv[0], hm[0], m[7:0])), "R1 R2 R4 R5 R6 sweep");
          end
        end
      end
    end

    hivec_sel = 0; halt_mode = 0;
    wr_en(8'h01);
    fetch(32'h0, 3'd2);
    wr_en(8'h00);
    commit_chk(3'd2, 1, "R3 later disable ignored");
    fetch(32'h4, 3'd2);
    wr_en(8'h02);
    commit_chk(3'd2, 0, "R3 later enable ignored");

    halt_mode = 1; wr_en(8'h18);
    fetch(32'hC, 3'd1);
    halt_mode = 0;
    commit_chk(3'd1, 1, "R4 halt sampled at fetch");
    fetch(32'h10, 3'd1);
    halt_mode = 1;
    commit_chk(3'd1, 0, "R4 halt off at fetch");

    wr_en(8'hDF);
    fetch(32'h0, 3'd4);
    commit_chk(3'd4, 1, "R9 first commit");
    commit_chk(3'd4, 0, "R9 second commit silent");

    fetch(32'h4, 3'd5);
    fetch(32'h8, 3'd6);
    fetch(32'h20, 3'd7);
    commit_chk(3'd6, 1, "R6 out of order tag 6");
    commit_chk(3'd7, 0, "R9 unmatched tag 7");
    commit_chk(3'd5, 1, "R6 out of order tag 5");

    fetch(32'h0, 3'd0);
    fetch(32'h4, 3'd3);
    @(negedge clk); cancel = 1; commit_valid = 1; commit_tag = 3'd0;
    @(negedge clk); cancel = 0; commit_valid = 0;
    check("R7 commit with cancel reported", int'(catch_evt), 1);
    commit_chk(3'd3, 0, "R7 cancelled tag silent");

    @(negedge clk); cancel = 1; pf_valid = 1; pf_addr = 32'h18; pf_tag = 3'd2;
    @(negedge clk); cancel = 0; pf_valid = 0;
    commit_chk(3'd2, 1, "R7 fetch with cancel kept");

    fetch(32'h1C, 3'd1);
    @(negedge clk); cancel = 1;
    @(negedge clk); cancel = 0;
    commit_chk(3'd1, 0, "R7 cancel discards");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule